// File: doc/BRIEF.md
# Input Pin Change-of-State Detector

This block samples four asynchronous input pins shared by two serial channels. Each pin goes through a two-stage synchronizer. A small per-pin state machine then latches any transition into a sticky change flag. Software sees the live levels and the flags in one byte, through three read-only views selected by a two-bit view select and qualified by a read strobe. The read data path is combinational: the byte appears on the same cycle as the strobe.

The flags are split between the channels by pin parity. Even pins (0 and 2) belong to channel A, and odd pins (1 and 3) belong to channel B. Reading a channel's view clears only that channel's flags, at the clock edge that ends the read. The debug view returns the same byte and never clears anything. View select codes are: 2'b00 channel A, 2'b01 channel B, 2'b10 debug, 2'b11 unused.

Each flag cell has two named states. FLAG_IDLE moves to FLAG_SEEN when an edge is detected. FLAG_SEEN stays put unless a clearing read arrives with no new edge, in which case it returns to FLAG_IDLE. An edge that coincides with a clear keeps the cell in FLAG_SEEN.

Top module: `pin_change_monitor`

## Requirements
- R1: Read data bits 3:0 give the synchronized level of pins 3..0 (1 = high, 0 = low). A pin change driven between two clock edges shows in bits 3:0 after the second following edge.
- R2: Read data bit 4+n is a sticky flag for pin n. It is set by any transition, whether rising, falling, or a pulse as short as one cycle. It becomes visible after the third clock edge following the pin change, and it stays set until cleared.
- R3: After reset all flags are 0 and the synchronized levels are 0.
- R4: A read with view select 2'b00 clears bits 4 and 6 (pins 0 and 2) and leaves bits 5 and 7 unchanged.
- R5: A read with view select 2'b01 clears bits 5 and 7 (pins 1 and 3) and leaves bits 4 and 6 unchanged.
- R6: A read with view select 2'b10 returns the same byte as the channel views and leaves all flags unchanged.
- R7: Bits 63:8 are always 0. When the read strobe is low, or the view select is 2'b11, read data is all 0 and no flag changes.
- R8: If a pin edge is detected in the same cycle as a read that clears that pin's flag, the flag is set after that cycle.
- R9: A clearing read returns the flag values as they stood before the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 4 | Asynchronous external input pins |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | View select (00 channel A, 01 channel B, 10 debug, 11 unused) |
| rd_data | output | 64 | Read data: levels in 3:0, flags in 7:4, zeros above |

## Verification
The assertions check on every cycle that each flag cell follows its state rules. A detected edge always leaves the flag set, even against a clear. A clear with no edge empties the flag. With neither, the flag holds. The assertions also check that the upper read bits stay zero, that an idle or unused-select read returns zero, and that a debug read changes no flag. Only the bench's scenarios can show the external timing: the two-edge level latency, the three-edge flag latency, the correct split of clear bits per channel view for every toggle pattern, and that a clearing read returns the pre-clear byte.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    localparam int PCM_NUM_PINS = 4;
    localparam int PCM_DATA_W   = 64;

    typedef enum logic [1:0] {
        VIEW_CHAN_A = 2'b00,
        VIEW_CHAN_B = 2'b01,
        VIEW_DEBUG  = 2'b10,
        VIEW_NONE   = 2'b11
    } view_sel_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_SEEN = 1'b1
    } flag_state_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcm_flag_cell.sv
module pcm_flag_cell
    import pcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clear_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;
    logic        level_q;
    logic        edge_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    assign edge_w = level_i ^ level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: state_d = edge_w ? FLAG_SEEN : FLAG_IDLE;
            FLAG_SEEN: state_d = (clear_i && !edge_w) ? FLAG_IDLE : FLAG_SEEN;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    assign flag_o = (state_q == FLAG_SEEN);

    // R2 / R8: a level change seen at the cell input always leaves the flag set
    assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i != level_q) |=> flag_o);

    // R4 / R5: clear without a fresh edge empties the flag
    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && level_i == level_q) |=> !flag_o);

    // R2: with neither edge nor clear the flag holds
    assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && level_i == level_q) |=> $stable(flag_o));
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor
    import pcm_pkg::*;
#(
    parameter int NUM_PINS    = PCM_NUM_PINS,
    parameter int DATA_W      = PCM_DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                rd_en,
    input  logic [1:0]          rd_sel,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int BYTE_W = 2 * NUM_PINS;
    localparam int PAD_W  = DATA_W - BYTE_W;

    logic [NUM_PINS-1:0] level_w;
    logic [NUM_PINS-1:0] flag_w;
    logic [NUM_PINS-1:0] clear_w;
    view_sel_e           sel_w;
    logic                view_ok_w;

    assign sel_w     = view_sel_e'(rd_sel);
    assign view_ok_w = rd_en && (sel_w != VIEW_NONE);

    pcm_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (level_w)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        if (p % 2 == 0) begin : g_chan_a
            assign clear_w[p] = rd_en && (sel_w == VIEW_CHAN_A);
        end else begin : g_chan_b
            assign clear_w[p] = rd_en && (sel_w == VIEW_CHAN_B);
        end

        pcm_flag_cell cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .level_i(level_w[p]),
            .clear_i(clear_w[p]),
            .flag_o (flag_w[p])
        );
    end

    always_comb begin
        rd_data = '0;
        if (view_ok_w) rd_data = {{PAD_W{1'b0}}, flag_w, level_w};
    end

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:BYTE_W] == '0);

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !view_ok_w |-> (rd_data == '0));

    assert_idle_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!view_ok_w && flag_w != '0) |=> (flag_w != '0));

    assert_debug_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_w == VIEW_DEBUG) |=> ((flag_w & $past(flag_w)) == $past(flag_w)));
endmodule

// File: tb/pin_change_monitor_tb.sv
module pin_change_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_in = 4'h0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'b11;
    logic [63:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pin_change_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_read(logic [1:0] sel, output logic [63:0] data);
        rd_sel = sel; rd_en = 1'b1;
        #1 data = rd_data;
        step(1);
        rd_en = 1'b0; rd_sel = 2'b11;
    endtask

    function automatic logic [63:0] byte_of(logic [3:0] fl, logic [3:0] lv);
        return {56'h0, fl, lv};
    endfunction

    initial begin
        logic [63:0] d;
        logic [3:0]  pins;
        logic [3:0]  keep;
        pins = 4'h0;
        step(3);
        rst_n = 1'b1;
        step(2);

        // R3: reset state
        do_read(2'b10, d);
        check("R3 reset byte", d, 64'h0);

        // R7: idle strobe and unused select return zero
        #1 check("R7 idle zero", rd_data, 64'h0);

        // R1 latency: level appears after second edge
        pins = 4'b0101; pin_in = pins;
        step(1);
        rd_sel = 2'b10; rd_en = 1'b1; #1;
        check("R1 level not yet", {60'h0, rd_data[3:0]}, 64'h0);
        rd_en = 1'b0;
        step(1);
        rd_sel = 2'b10; rd_en = 1'b1; #1;
        check("R1 level after two edges", {60'h0, rd_data[3:0]}, 64'h5);
        check("R2 flag not before third edge", {60'h0, rd_data[7:4]}, 64'h0);
        rd_en = 1'b0;
        step(1);
        do_read(2'b10, d);
        check("R2 flag after third edge", d, byte_of(4'b0101, pins));
        do_read(2'b00, d);
        do_read(2'b01, d);

        // Sweep every toggle mask against every view
        for (int m = 0; m < 16; m++) begin
            for (int v = 0; v < 3; v++) begin
                pins = pins ^ m[3:0]; pin_in = pins;
                step(3);
                do_read(2'b10, d);
                check("R6 debug byte", d, byte_of(m[3:0], pins));
                do_read(v[1:0], d);
                check("R9 pre-clear byte", d, byte_of(m[3:0], pins));
                keep = (v == 0) ? (m[3:0] & 4'b1010) :
                       (v == 1) ? (m[3:0] & 4'b0101) : m[3:0];
                do_read(2'b10, d);
                if (v == 0)      check("R4 chan A clear", d, byte_of(keep, pins));
                else if (v == 1) check("R5 chan B clear", d, byte_of(keep, pins));
                else             check("R6 debug no clear", d, byte_of(keep, pins));
                do_read(2'b00, d);
                do_read(2'b01, d);
            end
        end

        // R7: unused select gives zero and clears nothing
        pins = pins ^ 4'hF; pin_in = pins;
        step(3);
        do_read(2'b11, d);
        check("R7 unused select zero", d, 64'h0);
        do_read(2'b10, d);
        check("R7 unused select no clear", d, byte_of(4'hF, pins));
        do_read(2'b00, d);
        do_read(2'b01, d);

        // R2: one-cycle pulse on pin 1 still sets the flag
        pin_in = pins ^ 4'b0010;
        step(1);
        pin_in = pins;
        step(4);
        do_read(2'b10, d);
        check("R2 short pulse", d, byte_of(4'b0010, pins));
        do_read(2'b01, d);

        // R8: edge on pin 0 coincides with channel A clear
        pins = pins ^ 4'b0001; pin_in = pins;
        step(2);
        do_read(2'b00, d);
        check("R8 read during edge returns old flag", {60'h0, d[7:4]}, 64'h0);
        do_read(2'b10, d);
        check("R8 flag survives clear", d, byte_of(4'b0001, pins));
        do_read(2'b00, d);
        do_read(2'b10, d);
        check("R4 later clear works", d, byte_of(4'b0000, pins));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2ms;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule